// File: doc/BRIEF.md
# Mode-Selectable Four-Requester Bus Arbiter

This block shares one upstream bus among four internal requesters: a 1394 host function, a CardBus function, a flash-media function and an SD host function. Each requester has one request line and one grant line. A 2-bit mode field chooses the arbitration policy. The policy can favour the 1394 host, favour CardBus, run a flat round robin over all four, or run a two-level grouped round robin. In the grouped scheme the flash/SD pair is served first and the CardBus/1394 pair only when that pair is idle.

A per-requester disable input takes a function out of arbitration completely. After a grant is issued, it holds until its owner drops the request or pulses the transaction-end input. The bus then stays idle for one cycle, and the next decision is made on that free bus. Changing the mode never disturbs a grant in progress. A function-level reset clears the grant and the rotation pointers but leaves the mode field alone. The global reset returns the mode to flat round robin.

Top module: `bus_arb4`

## Requirements
- R1: After global reset `gnt` is 0000 and `cur_mode` is 11. Bit positions of `req`, `off` and `gnt` are 0 = 1394 host, 1 = CardBus, 2 = flash media, 3 = SD host.
- R2: In mode 11, each decision grants the first active requester found in increasing index order, wrapping around, starting just after the last requester granted. After reset, that search starts at index 0.
- R3: In mode 00, an active 1394 host (bit 0) always wins the decision. When it is idle, the other requesters are chosen by the R2 rotation.
- R4: In mode 01, an active CardBus requester (bit 1) always wins the decision. When it is idle, the other requesters are chosen by the R2 rotation.
- R5: In mode 10, any active flash/SD requester wins over CardBus/1394. Within the flash/SD pair, grants alternate, and flash is preferred first after reset. Within the CardBus/1394 pair, grants alternate, and 1394 is preferred first after reset. Each pair keeps its own pointer.
- R6: A requester whose `off` bit is 1 is never granted. If its `off` bit rises while it holds the bus, its grant is removed on the next clock.
- R7: A grant stays unchanged while its owner keeps requesting and `xfer_done` is 0. The grant goes to 0000 on the clock after the owner drops its request or after `xfer_done` is 1. A new grant is issued only from an idle (0000) cycle.
- R8: At most one `gnt` bit is ever 1.
- R9: The mode changes only on a clock with `cfg_we` = 1, and only later decisions use it; a grant in progress is kept. A clock with `soft_rst` = 1 clears the grant and all pointers, but not the mode.
- R10: In mode 11 with all four requesters continuously active, four consecutive grants go to four distinct requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| soft_rst | input | 1 | Function-level synchronous reset, active high |
| cfg_we | input | 1 | Mode field write strobe |
| cfg_mode | input | 2 | Mode value to write |
| req | input | 4 | Request per requester |
| off | input | 4 | Disable per requester |
| xfer_done | input | 1 | Transaction end from the current owner |
| gnt | output | 4 | One-hot grant |
| cur_mode | output | 2 | Current mode field |

## Verification
The hardest case to reach is a pointer-dependent choice made just after events that shift the rotation. Examples are a mode change landing mid-grant, a function reset clearing the pointers, or a disable landing on the current owner. In all of these, the next winner depends on grant history rather than on the current request pattern. Directed sequences place mode writes, `off` edges and `soft_rst` pulses inside held grants. A long seeded random run then mixes all of them. A bench model tracks the pointers, so every cycle's grant is compared against the expected one.

// File: rtl/bus_arb4.sv
module bus_arb4 #(
  parameter int NREQ = 4,
  parameter int MW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            cfg_we,
  input  logic [MW-1:0]   cfg_mode,
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] off,
  input  logic            xfer_done,
  output logic [NREQ-1:0] gnt,
  output logic [MW-1:0]   cur_mode
);
  localparam int IW = $clog2(NREQ);

  logic [NREQ-1:0] gnt_q, pick, flat;
  logic [MW-1:0]   mode_q;
  logic [IW-1:0]   last_q;
  logic            pair_hi_q, pair_lo_q;

  wire [NREQ-1:0] act  = req & ~off;
  wire            busy = |gnt_q;
  wire            keep = |(gnt_q & act) && !xfer_done;

  always_comb begin
    flat = '0;
    for (int k = 1; k <= NREQ; k++) begin
      logic [IW-1:0] idx;
      idx = last_q + IW'(k);
      if (act[idx] && flat == '0) flat[idx] = 1'b1;
    end
  end

  always_comb begin
    pick = '0;
    case (mode_q)
      2'b00: pick = act[0] ? 4'b0001 : flat;
      2'b01: pick = act[1] ? 4'b0010 : flat;
      2'b10: begin
        if (|act[3:2])
          pick = (act[2] && (pair_hi_q || !act[3])) ? 4'b0100 : 4'b1000;
        else if (|act[1:0])
          pick = (act[0] && (pair_lo_q || !act[1])) ? 4'b0001 : 4'b0010;
      end
      default: pick = flat;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q     <= '0;
      mode_q    <= 2'b11;
      last_q    <= IW'(NREQ - 1);
      pair_hi_q <= 1'b1;
      pair_lo_q <= 1'b1;
    end else begin
      if (cfg_we) mode_q <= cfg_mode;
      if (soft_rst) begin
        gnt_q     <= '0;
        last_q    <= IW'(NREQ - 1);
        pair_hi_q <= 1'b1;
        pair_lo_q <= 1'b1;
      end else if (busy) begin
        if (!keep) gnt_q <= '0;
      end else if (|pick) begin
        gnt_q  <= pick;
        last_q <= {pick[3] | pick[2], pick[3] | pick[1]};
        if (pick[2]) pair_hi_q <= 1'b0;
        if (pick[3]) pair_hi_q <= 1'b1;
        if (pick[0]) pair_lo_q <= 1'b0;
        if (pick[1]) pair_lo_q <= 1'b1;
      end
    end
  end

  assign gnt      = gnt_q;
  assign cur_mode = mode_q;
endmodule

module bus_arb4_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       cfg_we,
  input logic [3:0] req,
  input logic [3:0] off,
  input logic       xfer_done,
  input logic [3:0] gnt,
  input logic [1:0] cur_mode
);
  assert_onehot_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_new_grant_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    |(gnt & ~$past(gnt)) |-> |(gnt & $past(req) & ~$past(off)));

  assert_disable_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    |(gnt & off) |=> gnt == 4'b0000);

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & req & ~off) && !xfer_done && !soft_rst) |=> gnt == $past(gnt));

  assert_idle_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    |gnt |=> (gnt == $past(gnt) || gnt == 4'b0000));

  assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cur_mode));

  assert_soft_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> gnt == 4'b0000);
endmodule

bind bus_arb4 bus_arb4_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
  .req(req), .off(off), .xfer_done(xfer_done), .gnt(gnt), .cur_mode(cur_mode)
);

// File: tb/bus_arb4_tb.sv
`timescale 1ns/1ps
module bus_arb4_tb;
  logic       clk = 0, rst_n = 0, soft_rst = 0, cfg_we = 0, xfer_done = 0;
  logic [1:0] cfg_mode = 0, cur_mode;
  logic [3:0] req = 0, off = 0, gnt;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [3:0] m_gnt;
  logic [1:0] m_mode, m_last;
  logic       m_hi, m_lo;

  always #2 clk = ~clk;

  bus_arb4 u_dut (.clk, .rst_n, .soft_rst, .cfg_we, .cfg_mode, .req, .off,
                  .xfer_done, .gnt, .cur_mode);

  function automatic logic [3:0] flat_pick(logic [3:0] a, logic [1:0] last);
    for (int k = 1; k <= 4; k++) begin
      logic [1:0] i = last + 2'(k);
      if (a[i]) return 4'b0001 << i;
    end
    return 4'b0000;
  endfunction

  function automatic logic [3:0] exp_pick(logic [3:0] a);
    case (m_mode)
      2'b00: return a[0] ? 4'b0001 : flat_pick(a, m_last);
      2'b01: return a[1] ? 4'b0010 : flat_pick(a, m_last);
      2'b10: begin
        if (a[2] && a[3]) return m_hi ? 4'b0100 : 4'b1000;
        if (a[2]) return 4'b0100;
        if (a[3]) return 4'b1000;
        if (a[0] && a[1]) return m_lo ? 4'b0001 : 4'b0010;
        if (a[0]) return 4'b0001;
        if (a[1]) return 4'b0010;
        return 4'b0000;
      end
      default: return flat_pick(a, m_last);
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset_ptrs();
    m_gnt = 0; m_last = 2'd3; m_hi = 1; m_lo = 1;
  endtask

  task automatic model_next();
    logic [3:0] a = req & ~off;
    logic [3:0] p = exp_pick(a);
    logic [1:0] nm = cfg_we ? cfg_mode : m_mode;
    if (soft_rst) model_reset_ptrs();
    else if (m_gnt != 0) begin
      if (!(|(m_gnt & a)) || xfer_done) m_gnt = 0;
    end else if (p != 0) begin
      m_gnt = p;
      m_last = {p[3] | p[2], p[3] | p[1]};
      if (p[2]) m_hi = 0;
      if (p[3]) m_hi = 1;
      if (p[0]) m_lo = 0;
      if (p[1]) m_lo = 1;
    end
    m_mode = nm;
  endtask

  task automatic chk(logic ok, string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [3:0] r, logic [3:0] o, logic d, logic w,
                      logic [1:0] m, logic s);
    string tag = mode_tag(m_mode);
    req = r; off = o; xfer_done = d; cfg_we = w; cfg_mode = m; soft_rst = s;
    model_next();
    @(posedge clk); @(negedge clk);
    chk(gnt == m_gnt, tag, gnt, m_gnt);
    chk(cur_mode == m_mode, "R9", {2'b00, cur_mode}, {2'b00, m_mode});
  endtask

  task automatic lit(logic [3:0] exp, string tag);
    chk(gnt == exp, tag, gnt, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] seen;
    void'($urandom(32'd1234));
    m_mode = 2'b11;
    model_reset_ptrs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    lit(4'b0000, "R1");
    chk(cur_mode == 2'b11, "R1", {2'b00, cur_mode}, 4'b0011);

    // R2 / R10: flat rotation with all requesting
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      step(4'hF, 0, 0, 0, 0, 0);
      lit(4'b0001 << k, "R2");
      seen |= gnt;
      step(4'hF, 0, 0, 0, 0, 0);
      lit(4'b0001 << k, "R7");
      step(4'hF, 0, 1, 0, 0, 0);
      lit(4'b0000, "R7");
    end
    chk(seen == 4'hF, "R10", seen, 4'hF);

    // R3: 1394 favoured
    step(0, 0, 0, 1, 2'b00, 1);
    lit(4'b0000, "R9");
    for (int k = 0; k < 2; k++) begin
      step(4'hF, 0, 0, 0, 0, 0); lit(4'b0001, "R3");
      step(4'hE, 0, 0, 0, 0, 0); lit(4'b0000, "R7");
    end
    step(4'hE, 0, 0, 0, 0, 0); lit(4'b0010, "R3");
    step(4'hE, 0, 1, 0, 0, 0);
    step(4'hE, 0, 0, 0, 0, 0); lit(4'b0100, "R3");

    // R4: CardBus favoured
    step(0, 0, 0, 1, 2'b01, 1);
    step(4'hF, 0, 0, 0, 0, 0); lit(4'b0010, "R4");
    step(4'hD, 0, 0, 0, 0, 0);
    step(4'hD, 0, 0, 0, 0, 0); lit(4'b0100, "R4");

    // R5: grouped
    step(0, 0, 0, 1, 2'b10, 1);
    step(4'hF, 0, 0, 0, 0, 0); lit(4'b0100, "R5");
    step(4'hF, 0, 1, 0, 0, 0);
    step(4'hF, 0, 0, 0, 0, 0); lit(4'b1000, "R5");
    step(4'hF, 0, 1, 0, 0, 0);
    step(4'hF, 0, 0, 0, 0, 0); lit(4'b0100, "R5");
    step(4'h3, 0, 0, 0, 0, 0); lit(4'b0000, "R7");
    step(4'h3, 0, 0, 0, 0, 0); lit(4'b0001, "R5");
    step(4'h3, 0, 1, 0, 0, 0);
    step(4'h3, 0, 0, 0, 0, 0); lit(4'b0010, "R5");
    step(0, 0, 0, 0, 0, 0);

    // R6: disabled requester ignored, and dropped mid-grant
    step(4'h4, 4'h4, 0, 0, 0, 0); lit(4'b0000, "R6");
    step(4'h4, 4'h4, 0, 0, 0, 0); lit(4'b0000, "R6");
    step(4'h4, 0, 0, 0, 0, 0); lit(4'b0100, "R6");
    step(4'h4, 4'h4, 0, 0, 0, 0); lit(4'b0000, "R6");

    // R9: mode write mid-grant keeps grant; soft reset keeps mode
    step(4'h8, 0, 0, 0, 0, 0); lit(4'b1000, "R9");
    step(4'h9, 0, 0, 1, 2'b00, 0); lit(4'b1000, "R9");
    step(4'h9, 0, 0, 0, 0, 0); lit(4'b1000, "R9");
    step(4'h9, 0, 0, 0, 0, 1); lit(4'b0000, "R9");
    chk(cur_mode == 2'b00, "R9", {2'b00, cur_mode}, 4'b0000);
    step(4'h9, 0, 0, 0, 0, 0); lit(4'b0001, "R3");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] r = 4'($urandom);
      logic [3:0] o = ($urandom % 8 == 0) ? 4'($urandom) : 4'b0000;
      logic       d = ($urandom % 5 == 0);
      logic       w = ($urandom % 25 == 0);
      logic       s = ($urandom % 120 == 0);
      step(r, o, d, w, 2'($urandom), s);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule